// File: doc/BRIEF.md
# ADC control and status sequencer

This block sits between a register bus and an external analog-to-digital conversion engine. Software programs one 8-bit control/status register to pick a channel, enable the interrupt and start conversion. The block then hands the engine a one-cycle start pulse with a channel number and waits for the engine's done pulse. When the done pulse arrives, the block stores the sample in that channel's result register.

The conversion mode comes from an input pin. In single mode, one conversion of the selected channel runs, and then the start bit drops by itself. In scan mode, channels 0 up to the selected channel are converted in turn, over and over, until software clears the start bit. A conversion-end flag is raised once per single conversion, or once per completed scan pass. The interrupt request follows that flag, gated by the enable bit. The flag is cleared either by a software write of 0 that follows a read showing it set, or by a DMA result-read strobe.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset the control/status register (address 0) reads 0x00, every result register (addresses 1..4) reads 0x00, and irq_o and conv_start_o are low.
- R2: Bit 4 of the control/status register always reads 0, and writing 1 to it changes nothing.
- R3: A write that sets the start bit (bit 5) makes conv_start_o pulse for exactly one cycle, in the cycle after the write. In single mode, conv_ch_o equals bits 1:0 of the channel field (bits 3:0).
- R4: When a single-mode conversion ends, the converter data is stored at address 1+channel, the start bit reads 0, and the end flag (bit 7) reads 1.
- R5: In scan mode (scan_i=1), channels 0..sel are converted in ascending order and then wrap to 0, where sel is channel field bits 1:0. The end flag sets after each finished pass, and the start bit stays 1.
- R6: Writing 0 to the start bit stops the sequence. No further conv_start_o pulse follows, and the start bit reads 0.
- R7: Writing 0 to bit 7 clears the end flag only if the flag was read as 1 since it was last set. Writing 1 to bit 7 never changes the flag.
- R8: A one-cycle pulse on dma_rd_i clears the end flag.
- R9: irq_o is high exactly when the end flag and the interrupt enable (bit 6) are both 1.
- R10: A flag set by the hardware in the same cycle as a software clear leaves the flag at 1. That set also cancels the earlier read, so a later write of 0 with no new read leaves the flag at 1.
- R11: A change to the channel field during a scan takes effect from the next conversion: the pass ends at the new limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 3 | Register address: 0 is the control/status register, 1..4 are the results |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i |
| scan_i | input | 1 | 1 selects scan mode, 0 selects single mode |
| dma_rd_i | input | 1 | DMA result-read strobe, clears the end flag |
| conv_start_o | output | 1 | One-cycle start pulse to the converter |
| conv_ch_o | output | 2 | Channel being converted |
| conv_done_i | input | 1 | Converter done pulse |
| conv_data_i | input | 8 | Converter sample, valid with conv_done_i |
| irq_o | output | 1 | Conversion-end interrupt request |

## Verification
The bench sweeps every channel setting in both modes. It checks the order in which channels are converted, where each scan pass wraps, and the stored results. A design that restarted a scan at the wrong channel, or that dropped the start bit in scan mode, would fail the ordering and status checks. The flag handshake is driven through every path: a write of 0 with no prior read, a write of 1, a DMA clear, and a software clear landing in the same cycle as a hardware set. A design that cleared the flag without a prior read, or that lost an event arriving between the read and the write, would leave irq_o wrong. The bench also narrows the channel field during a running scan and checks that the next pass stops at the new limit, and it checks that a stop leaves the converter quiet.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [0:0] {SEQ_IDLE = 1'b0, SEQ_CONV = 1'b1} seq_state_e;

  localparam int unsigned CsrFlagBit  = 7;
  localparam int unsigned CsrIeBit    = 6;
  localparam int unsigned CsrStartBit = 5;
  localparam int unsigned CsrChLsb    = 0;
  localparam int unsigned CsrChW      = 4;
  localparam int unsigned CsrW        = 8;
endpackage

// File: rtl/adc_csr.sv
module adc_csr
  import adc_seq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [CsrW-1:0]   wdata_i,
  input  logic              hw_set_i,
  input  logic              hw_clr_start_i,
  input  logic              dma_rd_i,
  output logic              flag_o,
  output logic              ie_o,
  output logic              start_o,
  output logic [CsrChW-1:0] ch_o,
  output logic [CsrW-1:0]   csr_rd_o
);
  logic              flag_q, armed_q, ie_q, start_q;
  logic [CsrChW-1:0] ch_q;
  logic              sw_clr;

  assign sw_clr = wr_en_i && !wdata_i[CsrFlagBit] && armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ie_q    <= 1'b0;
      start_q <= 1'b0;
      ch_q    <= '0;
    end else if (wr_en_i) begin
      ie_q    <= wdata_i[CsrIeBit];
      start_q <= wdata_i[CsrStartBit];
      ch_q    <= wdata_i[CsrChLsb +: CsrChW];
    end else if (hw_clr_start_i) begin
      start_q <= 1'b0;
    end
  end

  // hardware set beats any clear and cancels a pending read-arm
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q  <= 1'b0;
      armed_q <= 1'b0;
    end else if (hw_set_i) begin
      flag_q  <= 1'b1;
      armed_q <= 1'b0;
    end else if (sw_clr || dma_rd_i) begin
      flag_q  <= 1'b0;
      armed_q <= 1'b0;
    end else if (rd_en_i && flag_q) begin
      armed_q <= 1'b1;
    end
  end

  assign flag_o   = flag_q;
  assign ie_o     = ie_q;
  assign start_o  = start_q;
  assign ch_o     = ch_q;
  assign csr_rd_o = {flag_q, ie_q, start_q, 1'b0, ch_q};

  assert_set_wins_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hw_set_i |=> flag_q);
  assert_single_autoclr_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hw_clr_start_i && !wr_en_i) |=> !start_q);
  assert_clear_needs_arm_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(flag_q) |-> $past(armed_q || dma_rd_i));
endmodule

// File: rtl/adc_sequencer.sv
module adc_sequencer
  import adc_seq_pkg::*;
#(
  parameter int unsigned NUM_CH = 4,
  localparam int unsigned CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_en_i,
  input  logic            scan_i,
  input  logic [CH_W-1:0] sel_i,
  input  logic            conv_done_i,
  output logic            conv_start_o,
  output logic [CH_W-1:0] conv_ch_o,
  output logic            res_we_o,
  output logic            hw_set_o,
  output logic            hw_clr_start_o
);
  seq_state_e      state_q;
  logic [CH_W-1:0] cur_q, scan_idx_q;
  logic            scan_q, start_q;
  logic            done_ev, last_hit;

  assign done_ev  = (state_q == SEQ_CONV) && start_en_i && conv_done_i;
  assign last_hit = cur_q >= sel_i;  // >= covers a limit lowered mid-pass

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= SEQ_IDLE;
      cur_q      <= '0;
      scan_idx_q <= '0;
      scan_q     <= 1'b0;
      start_q    <= 1'b0;
    end else begin
      start_q <= 1'b0;
      unique case (state_q)
        SEQ_IDLE: begin
          if (start_en_i) begin
            state_q <= SEQ_CONV;
            start_q <= 1'b1;
            scan_q  <= scan_i;
            cur_q   <= scan_i ? scan_idx_q : sel_i;
          end else begin
            scan_idx_q <= '0;
          end
        end
        SEQ_CONV: begin
          if (!start_en_i) begin
            state_q    <= SEQ_IDLE;
            scan_idx_q <= '0;
          end else if (conv_done_i) begin
            state_q <= SEQ_IDLE;
            if (scan_q) scan_idx_q <= last_hit ? '0 : cur_q + 1'b1;
          end
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  assign conv_start_o   = start_q;
  assign conv_ch_o      = cur_q;
  assign res_we_o       = done_ev;
  assign hw_set_o       = done_ev && (!scan_q || last_hit);
  assign hw_clr_start_o = done_ev && !scan_q;

  assert_start_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_start_o |=> !conv_start_o);
  assert_start_enabled_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(conv_start_o) |-> $past(start_en_i));
  assert_stop_idles_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_en_i |=> !conv_start_o);
endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank #(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned RES_W  = 8,
  localparam int unsigned CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CH_W-1:0]  wr_idx_i,
  input  logic [RES_W-1:0] wr_data_i,
  input  logic [CH_W-1:0]  rd_idx_i,
  output logic [RES_W-1:0] rd_data_o
);
  logic [RES_W-1:0] res_q [NUM_CH];

  for (genvar gi = 0; gi < NUM_CH; gi++) begin : g_res
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 res_q[gi] <= '0;
      else if (we_i && (wr_idx_i == CH_W'(gi)))    res_q[gi] <= wr_data_i;
    end
  end

  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < NUM_CH; i++)
      if (rd_idx_i == CH_W'(i)) rd_data_o = res_q[i];
  end
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int unsigned NUM_CH = 4,
  localparam int unsigned CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int unsigned ADDR_W = $clog2(NUM_CH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  input  logic              scan_i,
  input  logic              dma_rd_i,
  output logic              conv_start_o,
  output logic [CH_W-1:0]   conv_ch_o,
  input  logic              conv_done_i,
  input  logic [7:0]        conv_data_i,
  output logic              irq_o
);
  logic              csr_hit, res_hit;
  logic              flag, ie, start_en, hw_set, hw_clr_start, res_we;
  logic [CsrChW-1:0] ch_field;
  logic [7:0]        csr_rd, res_rd;
  logic [CH_W-1:0]   rd_idx;

  assign csr_hit = (addr_i == '0);
  assign res_hit = !csr_hit && (addr_i <= ADDR_W'(NUM_CH));
  assign rd_idx  = CH_W'(addr_i - 1'b1);

  adc_csr u_csr (
    .clk_i, .rst_ni,
    .wr_en_i        (wr_en_i && csr_hit),
    .rd_en_i        (rd_en_i && csr_hit),
    .wdata_i,
    .hw_set_i       (hw_set),
    .hw_clr_start_i (hw_clr_start),
    .dma_rd_i,
    .flag_o         (flag),
    .ie_o           (ie),
    .start_o        (start_en),
    .ch_o           (ch_field),
    .csr_rd_o       (csr_rd)
  );

  adc_sequencer #(.NUM_CH(NUM_CH)) u_seq (
    .clk_i, .rst_ni,
    .start_en_i     (start_en),
    .scan_i,
    .sel_i          (ch_field[CH_W-1:0]),
    .conv_done_i,
    .conv_start_o,
    .conv_ch_o,
    .res_we_o       (res_we),
    .hw_set_o       (hw_set),
    .hw_clr_start_o (hw_clr_start)
  );

  adc_result_bank #(.NUM_CH(NUM_CH), .RES_W(8)) u_res (
    .clk_i, .rst_ni,
    .we_i      (res_we),
    .wr_idx_i  (conv_ch_o),
    .wr_data_i (conv_data_i),
    .rd_idx_i  (rd_idx),
    .rd_data_o (res_rd)
  );

  assign rdata_o = csr_hit ? csr_rd : (res_hit ? res_rd : 8'h00);
  assign irq_o   = flag && ie;
endmodule

// File: tb/adc_seq_ctrl_tb.sv
module adc_seq_ctrl_tb;
  localparam int LAT = 4;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic [2:0] addr = '0;
  logic       wr_en = 0, rd_en = 0, scan = 0, dma_rd = 0, conv_done = 0;
  logic [7:0] wdata = '0, conv_data = '0, rdata;
  logic       conv_start, irq;
  logic [1:0] conv_ch;

  int total = 0, bad = 0;
  int log_n = 0;
  int log_ch [256];
  logic [7:0] exp_res [4];
  bit model_on = 1'b1;

  always #5 clk = ~clk;

  adc_seq_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .wdata_i(wdata), .rdata_o(rdata), .scan_i(scan), .dma_rd_i(dma_rd),
    .conv_start_o(conv_start), .conv_ch_o(conv_ch), .conv_done_i(conv_done),
    .conv_data_i(conv_data), .irq_o(irq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wr_csr(input logic [7:0] v);
    @(negedge clk); addr = 0; wdata = v; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    @(negedge clk); addr = a; rd_en = 1; #1 v = rdata;
    @(negedge clk); rd_en = 0;
  endtask

  task automatic wait_log(input int target);
    for (int g = 0; g < 3000 && log_n < target; g++) @(negedge clk);
  endtask

  // converter model: done a fixed latency after start
  initial begin
    forever begin
      @(negedge clk);
      if (model_on && conv_start) begin
        automatic int mch = int'(conv_ch);
        if (log_n < 256) log_ch[log_n] = mch;
        log_n++;
        repeat (LAT - 1) @(negedge clk);
        conv_data = 8'(8'h35 + log_n * 23);
        exp_res[mch] = conv_data;
        conv_done = 1;
        @(negedge clk);
        conv_done = 0;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=0 exp=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int n0, m;
    bit ok;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    rd(0, v); chk(v == 8'h00, "R1 csr", v, 0);
    chk(!irq && !conv_start, "R1 irq/start", {irq, conv_start}, 0);
    for (int a = 1; a <= 4; a++) begin
      rd(3'(a), v); chk(v == 8'h00, "R1 result", v, 0);
    end

    // R2 reserved bit
    wr_csr(8'h10); rd(0, v); chk(v == 8'h00, "R2 reserved", v, 0);

    // single-mode sweep: R3 R4 R9 R7
    scan = 0;
    for (int s = 0; s < 4; s++) begin
      automatic logic ie = 1'(s & 1);
      n0 = log_n;
      wr_csr({1'b0, ie, 1'b1, 1'b0, 4'(s)});
      @(negedge clk);
      chk(conv_start && conv_ch == 2'(s), "R3 start pulse/ch", {conv_start, conv_ch}, {1'b1, 2'(s)});
      repeat (LAT + 4) @(negedge clk);
      chk(!conv_start, "R3 single pulse", conv_start, 0);
      chk(irq == ie, "R9 irq", irq, ie);
      rd(0, v); chk(v == {1'b1, ie, 1'b0, 1'b0, 4'(s)}, "R4 csr after done", v, {1'b1, ie, 2'b00, 4'(s)});
      rd(3'(s + 1), v); chk(v == exp_res[s], "R4 result", v, exp_res[s]);
      chk(log_n == n0 + 1, "R4 one conversion", log_n - n0, 1);
      wr_csr({1'b0, ie, 1'b0, 1'b0, 4'(s)});
      rd(0, v); chk(v[7] == 1'b0 && !irq, "R7 armed clear", v, 0);
    end

    // R7 unarmed write 0, write 1
    wr_csr(8'h62);
    repeat (LAT + 6) @(negedge clk);
    chk(irq, "R9 irq set", irq, 1);
    wr_csr(8'h40); chk(irq, "R7 unarmed 0 write", irq, 1);
    wr_csr(8'hC0); chk(irq, "R7 write 1", irq, 1);
    rd(0, v);
    wr_csr(8'hC0); chk(irq, "R7 armed write 1", irq, 1);
    wr_csr(8'h40); chk(!irq, "R7 armed write 0", irq, 0);

    // R8 DMA clear
    wr_csr(8'h63);
    repeat (LAT + 6) @(negedge clk);
    chk(irq, "R8 pre", irq, 1);
    @(negedge clk); dma_rd = 1; @(negedge clk); dma_rd = 0;
    chk(!irq, "R8 dma clear irq", irq, 0);
    rd(0, v); chk(v[7] == 1'b0, "R8 dma clear flag", v, 8'h43);

    // scan sweep: R5 R6
    scan = 1;
    for (int s = 0; s < 4; s++) begin
      automatic int need = 2 * (s + 1) + 1;
      n0 = log_n;
      wr_csr(8'h60 | 8'(s));
      wait_log(n0 + need);
      ok = 1;
      for (int i = 0; i < need; i++) if (log_ch[n0 + i] != i % (s + 1)) ok = 0;
      chk(ok, "R5 scan order", log_ch[n0 + need - 1], (need - 1) % (s + 1));
      rd(0, v); chk(v[7:5] == 3'b111, "R5 flag set, start held", v[7:5], 3'b111);
      wr_csr(8'h00);
      repeat (LAT + 4) @(negedge clk);
      m = log_n;
      repeat (40) @(negedge clk);
      chk(log_n == m, "R6 stopped", log_n - m, 0);
      rd(0, v); chk(v[5] == 1'b0, "R6 start reads 0", v, 0);
    end

    // R11 narrowing the scan limit mid-run
    n0 = log_n;
    wr_csr(8'h23);
    wait_log(n0 + 2);
    wr_csr(8'h21);
    m = log_n;
    wait_log(m + 7);
    ok = 1;
    for (int i = m + 1; i < m + 7; i++)
      if (log_ch[i] > 1 || log_ch[i] == log_ch[i - 1]) ok = 0;
    chk(ok, "R11 new limit", log_ch[m + 1], 0);
    wr_csr(8'h00);
    repeat (LAT + 40) @(negedge clk);

    // R10 set vs. clear in the same cycle
    model_on = 0; scan = 0;
    wr_csr(8'h60);
    @(negedge clk); conv_done = 1; conv_data = 8'h5A;
    @(negedge clk); conv_done = 0;
    rd(0, v); chk(v == 8'hC0, "R10 pre flag", v, 8'hC0);
    wr_csr(8'hE0);
    @(negedge clk);
    conv_done = 1; addr = 0; wdata = 8'h40; wr_en = 1;
    @(negedge clk); conv_done = 0; wr_en = 0;
    chk(irq, "R10 set wins", irq, 1);
    wr_csr(8'h40); chk(irq, "R10 arm dropped", irq, 1);
    rd(0, v); wr_csr(8'h40); chk(!irq, "R10 rearmed clear", irq, 0);
    model_on = 1;

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule